// File: doc/BRIEF.md
# Scan Decimation Sample Filter

This block sits in the sample stream that leaves a converter FIFO. The converter runs from a single pacing timer, so every scan is converted at the convert rate. A slower scan rate is obtained by keeping one scan and discarding the next D scans. The filter works through repeating groups of N·(1+D) raw samples, where N is the scan length and D is the scan skip count. It forwards the first N samples of each group and drops the rest. Each kept sample is turned from the converter's offset-binary code into a signed code. Samples arrive and leave on valid/ready handshakes.

A start pulse captures the configuration. It also loads a stop counter with scans·N·(1+D) raw samples. The counter goes down by one for every raw sample consumed, whether the sample is kept or dropped. When the counter reaches zero the block raises an end-of-acquisition flag. From then on it accepts and discards input until the next start. In continuous mode the counter is ignored and the acquisition never ends.

Top module: `scan_decim_filter`

## Requirements
- R1: After reset, outValid and acqDone are 0, and inReady is 1 while start is low. The block is idle, and input is accepted and discarded.
- R2: During a cycle with start high, inReady is 0. The start captures N, D, the mode bits and the stop count scans·N·(1+D), and it resets the group position to 0. A start that arrives during a run restarts the grouping.
- R3: Within each group of N·(1+D) accepted samples, the first N are forwarded in arrival order and the remaining N·D are dropped. The group position wraps to 0 after the last sample of the group.
- R4: With D = 0, every accepted sample is forwarded in order.
- R5: With the narrow flag low (16-bit data), the forwarded value is raw XOR 0x8000.
- R6: With the narrow flag high (12-bit data), the forwarded value is ((raw >> 4) AND 0xFFF) XOR 0x800, and bits 15:12 are 0.
- R7: In counted mode, every accepted raw sample decrements the stop count. This includes dropped samples. acqDone rises in the cycle after the accept that brings the count to zero, and it stays high until the next start. The final sample is still forwarded if it falls in a keep slot.
- R8: With the continuous flag set, acqDone stays 0 and forwarding goes on without limit.
- R9: While not running (after reset or after end of acquisition), inReady is 1 except in a start cycle, and no accepted sample reaches the output.
- R10: A held output (outValid high, outReady low) keeps outData stable. A sample in a keep slot is not accepted while the output register is full and not draining. A sample in a drop slot is accepted regardless of the output.
- R11: A start in counted mode with scans = 0 raises acqDone in the next cycle, and no sample is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms a new acquisition with the current configuration |
| cfgScanLen | input | LEN_W | Scan length N (1 or more) |
| cfgSkip | input | SKIP_W | Scans discarded after each kept scan (D) |
| cfgScans | input | SCAN_W | Scans to acquire in counted mode |
| cfgContinuous | input | 1 | Continuous mode: never end the acquisition |
| cfgNarrow | input | 1 | 1: 12-bit data left-aligned in 16 bits, 0: 16-bit data |
| inValid | input | 1 | Raw sample valid |
| inReady | output | 1 | Raw sample accepted |
| inData | input | 16 | Raw offset-binary sample |
| outValid | output | 1 | Converted sample valid |
| outReady | input | 1 | Downstream accepts the sample |
| outData | output | 16 | Converted sample |
| acqDone | output | 1 | End of acquisition reached |

## Verification
The bench targets three kinds of corner case. The first is the group boundary for several N and D pairs: a design that wraps its position one sample early or late would forward a sample from a dropped scan, or lose the first sample of a kept scan. The second is the stop count. Because dropped samples also count, a design that counted only forwarded samples would end the acquisition too late. The check on acqDone in the cycle after the last accept catches an off-by-one in either direction. The third is backpressure mixed with drop slots, along with the scans = 0 and restart-mid-run cases. A design that stalled on drop slots, overwrote a held output, or carried the old group position across a start would break the expected sample order.

// File: rtl/scan_decim_pkg.sv
package scan_decim_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // load a converted sample into the output register
    logic narrow;   // conversion mode latched at start
  } dpCtl_t;
endpackage

// File: rtl/scan_decim_ctrl.sv
module scan_decim_ctrl
  import scan_decim_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int SKIP_W = 4,
  parameter int SCAN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfgScanLen,
  input  logic [SKIP_W-1:0] cfgSkip,
  input  logic [SCAN_W-1:0] cfgScans,
  input  logic              cfgContinuous,
  input  logic              cfgNarrow,
  input  logic              inValid,
  input  logic              outSpace,
  output logic              inReady,
  output logic              acqDone,
  output dpCtl_t            ctl
);
  localparam int GRP_W  = LEN_W + SKIP_W + 1;
  localparam int STOP_W = SCAN_W + GRP_W;

  logic [GRP_W-1:0]  grpLenNext;
  logic [STOP_W-1:0] stopLoad;
  logic [GRP_W-1:0]  pos;
  logic [GRP_W-1:0]  grpLast;
  logic [LEN_W-1:0]  lenReg;
  logic [STOP_W-1:0] stopCnt;
  logic              running;
  logic              contReg;
  logic              narrowReg;
  logic              keepSlot;
  logic              accept;
  logic              emptyLoad;

  always_comb begin
    grpLenNext = GRP_W'(cfgScanLen) * (GRP_W'(cfgSkip) + GRP_W'(1));
    stopLoad   = STOP_W'(cfgScans) * STOP_W'(grpLenNext);
    emptyLoad  = (stopLoad == '0) && !cfgContinuous;
  end

  assign keepSlot = pos < GRP_W'(lenReg);
  assign inReady  = !start && (!running || !keepSlot || outSpace);
  assign accept   = inValid && inReady && running;

  assign ctl.capture = accept && keepSlot;
  assign ctl.narrow  = narrowReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos       <= '0;
      grpLast   <= '0;
      lenReg    <= '0;
      stopCnt   <= '0;
      running   <= 1'b0;
      acqDone   <= 1'b0;
      contReg   <= 1'b0;
      narrowReg <= 1'b0;
    end else if (start) begin
      pos       <= '0;
      grpLast   <= grpLenNext - GRP_W'(1);
      lenReg    <= cfgScanLen;
      stopCnt   <= stopLoad;
      contReg   <= cfgContinuous;
      narrowReg <= cfgNarrow;
      running   <= !emptyLoad;
      acqDone   <= emptyLoad;
    end else if (accept) begin
      pos <= (pos == grpLast) ? '0 : pos + GRP_W'(1);
      if (!contReg) begin
        stopCnt <= stopCnt - STOP_W'(1);
        if (stopCnt == STOP_W'(1)) begin
          running <= 1'b0;
          acqDone <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scan_decim_datapath.sv
module scan_decim_datapath
  import scan_decim_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSpace
);
  localparam int SHIFT = DATA_W - NARROW_W;

  logic [DATA_W-1:0]   wideCode;
  logic [NARROW_W-1:0] narrowCode;
  logic [DATA_W-1:0]   converted;

  always_comb begin
    wideCode   = inData ^ (DATA_W'(1) << (DATA_W - 1));
    narrowCode = inData[DATA_W-1 -: NARROW_W] ^ (NARROW_W'(1) << (NARROW_W - 1));
    converted  = ctl.narrow ? {{SHIFT{1'b0}}, narrowCode} : wideCode;
  end

  assign outSpace = !outValid || outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (ctl.capture) begin
      outValid <= 1'b1;
      outData  <= converted;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_decim_filter.sv
module scan_decim_filter
  import scan_decim_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int SKIP_W = 4,
  parameter int SCAN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfgScanLen,
  input  logic [SKIP_W-1:0] cfgSkip,
  input  logic [SCAN_W-1:0] cfgScans,
  input  logic              cfgContinuous,
  input  logic              cfgNarrow,
  input  logic              inValid,
  output logic              inReady,
  input  logic [15:0]       inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [15:0]       outData,
  output logic              acqDone
);
  dpCtl_t ctl;
  logic   outSpace;

  scan_decim_ctrl #(.LEN_W(LEN_W), .SKIP_W(SKIP_W), .SCAN_W(SCAN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgScanLen(cfgScanLen), .cfgSkip(cfgSkip), .cfgScans(cfgScans),
    .cfgContinuous(cfgContinuous), .cfgNarrow(cfgNarrow),
    .inValid(inValid), .outSpace(outSpace), .inReady(inReady),
    .acqDone(acqDone), .ctl(ctl)
  );

  scan_decim_datapath #(.DATA_W(16), .NARROW_W(12)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outSpace(outSpace)
  );
endmodule

// File: rtl/scan_decim_filter_chk.sv
module scan_decim_filter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        cfgContinuous,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [15:0] outData,
  input logic        acqDone
);
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  p_start_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !inReady);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    acqDone && !start |=> acqDone);

  p_done_drains_r9: assert property (@(posedge clk) disable iff (!rstN)
    acqDone && !start |-> inReady);

  p_cont_no_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    start && cfgContinuous |=> !acqDone);
endmodule

bind scan_decim_filter scan_decim_filter_chk u_chk (.*);

// File: tb/scan_decim_filter_test.sv
module scan_decim_filter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfgScanLen = '0;
  logic [3:0]  cfgSkip = '0;
  logic [7:0]  cfgScans = '0;
  logic        cfgContinuous = 1'b0;
  logic        cfgNarrow = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [15:0] outData;
  logic        acqDone;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          mPos, mN, mGrp;
  longint      mCnt;
  bit          mRun, mDone, mCont, mNarrow;
  logic [16:0] q[$];
  bit          holdPending;
  logic [15:0] holdVal;

  always #2 clk = ~clk;

  scan_decim_filter uut (.*);

  function automatic logic [15:0] convert(input logic [15:0] d, input bit nar);
    if (nar) return {4'b0000, d[15:4] ^ 12'h800};
    return d ^ 16'h8000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit st, input bit iv, input logic [15:0] d, input bit ordy);
    logic [16:0] head;
    start = st; inValid = iv; inData = d; outReady = ordy;
    #1;
    chk(outValid === (q.size() != 0), (mGrp == mN) ? "R4" : "R3", outValid, q.size() != 0);
    if (holdPending) chk(outData === holdVal, "R10", outData, holdVal);
    if (st) chk(inReady === 1'b0, "R2", inReady, 0);
    else if (!mRun) chk(inReady === 1'b1, "R9", inReady, 1);
    if (outValid && ordy && q.size() != 0) begin
      head = q.pop_front();
      chk(outData === head[15:0], head[16] ? "R6" : "R5", outData, head[15:0]);
    end
    holdPending = outValid && !ordy;
    holdVal = outData;
    if (st) begin
      mN = cfgScanLen; mGrp = cfgScanLen * (cfgSkip + 1);
      mCnt = longint'(cfgScans) * mGrp; mPos = 0;
      mCont = cfgContinuous; mNarrow = cfgNarrow;
      mDone = (mCnt == 0) && !mCont;
      mRun = !mDone;
    end else if (iv && inReady && mRun) begin
      if (mPos < mN) q.push_back({mNarrow, convert(d, mNarrow)});
      mPos = (mPos == mGrp - 1) ? 0 : mPos + 1;
      if (!mCont) begin
        mCnt--;
        if (mCnt == 0) begin mRun = 0; mDone = 1; end
      end
    end
    @(posedge clk); #1;
    chk(acqDone === mDone, mCont ? "R8" : "R7", acqDone, mDone);
    @(negedge clk);
  endtask

  task automatic runCfg(input int n, input int dk, input int sc, input bit cont,
                        input bit nar, input int ncyc, input int vp, input int rp);
    cfgScanLen = 4'(n); cfgSkip = 4'(dk); cfgScans = 8'(sc);
    cfgContinuous = cont; cfgNarrow = nar;
    cyc(1, 0, 16'h0, 1);
    if (sc == 0 && !cont) chk(acqDone === 1'b1, "R11", acqDone, 1);
    for (int k = 0; k < ncyc; k++)
      cyc(0, ($urandom % 100) < vp, 16'($urandom), ($urandom % 100) < rp);
    for (int k = 0; k < 3; k++) cyc(0, 0, 16'h0, 1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    mPos = 0; mN = 0; mGrp = 0; mCnt = 0; mRun = 0; mDone = 0;
    mCont = 0; mNarrow = 0; holdPending = 0; holdVal = '0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: idle state after reset
    chk(outValid === 1'b0, "R1", outValid, 0);
    chk(acqDone === 1'b0, "R1", acqDone, 0);
    chk(inReady === 1'b1, "R1", inReady, 1);
    @(negedge clk);
    // R9: input before any start is discarded
    for (int k = 0; k < 4; k++) cyc(0, 1, 16'h1234 + 16'(k), 1);
    // R4/R5/R7: D = 0, counted, full throughput
    runCfg(3, 0, 4, 0, 0, 20, 100, 100);
    // R9: after end of acquisition
    for (int k = 0; k < 5; k++) cyc(0, 1, 16'hABCD, 1);
    // R3/R10: skip with backpressure
    runCfg(2, 2, 3, 0, 0, 80, 70, 50);
    // R6: narrow data
    runCfg(4, 1, 2, 0, 1, 60, 80, 70);
    // R8: continuous
    runCfg(1, 3, 0, 1, 0, 120, 90, 80);
    // R11: empty count
    runCfg(3, 1, 0, 0, 0, 5, 100, 100);
    // R2: restart in the middle of a run
    runCfg(3, 2, 5, 0, 0, 7, 100, 100);
    runCfg(2, 1, 2, 0, 1, 30, 90, 60);
    // randomized configurations
    for (int t = 0; t < 12; t++)
      runCfg(1 + ($urandom % 5), $urandom % 4, $urandom % 4, ($urandom % 5) == 0,
             $urandom % 2, 200, 40 + ($urandom % 60), 30 + ($urandom % 70));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule